// File: doc/BRIEF.md
# Deferred Condition Code Evaluator

This block keeps the raw ingredients of the most recent flag-setting operation instead of finished flags. A record port captures an operation tag and five data-wide value slots (X, N, Z, V and C). The five-bit condition code register is rebuilt from them combinationally on every read. A direct write port loads explicit flags. A flush command replaces the slots with the evaluated flags and marks the state as explicit, so that later reads no longer need the evaluation path.

For add and subtract records only the result and the second source are kept. The first source is recovered by undoing the arithmetic and sign-extending to the operand size. For compare records both sources are kept and the result is rebuilt instead. Records for byte and word sizes must carry values that are already sign-extended to the full slot width. A record whose tag has no defined meaning is dropped and reported on an error output.

Top module: `lazy_ccr`

## Requirements
- R1: While rst_ni is low and after its release, with no other stimulus, ccr_o reads 5'b00000 and tag_err_o is 0.
- R2: ccr_o bit order is X=bit 4, N=bit 3, Z=bit 2, V=bit 1, C=bit 0. After a write with ccr_we_i, the next cycle reads back ccr_wdata_i exactly. With tag 0 (explicit flags), X is bit 0 of the X slot, N is bit DATA_W-1 of the N slot, Z is 1 when the Z slot is all zero, V is bit DATA_W-1 of the V slot, and C is bit 0 of the C slot. With no write, record or flush, ccr_o holds its value.
- R3: Add tags 1/2/3 (byte/word/long): the N slot holds the result, the V slot holds source 2 and the X slot holds the carry. C equals X, Z is set when the result is zero, and V flags signed overflow of source 1 + source 2. The Z and C slots are ignored.
- R4: Subtract tags 4/5/6 (byte/word/long): the slots are laid out as for add, and the X slot holds the borrow. C equals X, and V flags signed overflow of source 1 − source 2.
- R5: Compare tags 7/8/9 (byte/word/long): the N slot holds source 1 and the V slot holds source 2. N, Z and V describe source 1 − source 2 at the operand size. C is the unsigned source 1 < source 2. X is taken from the X slot.
- R6: Logic tag 10: N and Z come from the N slot, and V and C read 0 whatever the V and C slots hold.
- R7: Byte operations take their sign from bit 7, word operations from bit 15, and long operations from bit DATA_W-1. Flags for byte and word records match arithmetic done at 8 and 16 bits.
- R8: A flush leaves ccr_o unchanged, both for explicit flags and for an arithmetic or logic record.
- R9: A record with a tag of 11 to 15 leaves ccr_o unchanged and raises tag_err_o for exactly the following cycle. tag_err_o is 0 in every other cycle.
- R10: Within one cycle a direct write takes priority over a record, and a record takes priority over a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rec_valid_i | input | 1 | Capture a record this cycle |
| rec_tag_i | input | 4 | Operation tag of the record |
| rec_x_i | input | DATA_W | X slot value |
| rec_n_i | input | DATA_W | N slot value (result, or source 1 for compare) |
| rec_z_i | input | DATA_W | Z slot value |
| rec_v_i | input | DATA_W | V slot value (source 2 for arithmetic) |
| rec_c_i | input | DATA_W | C slot value |
| ccr_we_i | input | 1 | Direct condition code write |
| ccr_wdata_i | input | 5 | Flags to write |
| flush_i | input | 1 | Convert the stored state to explicit flags |
| ccr_o | output | 5 | Evaluated condition codes |
| tag_err_o | output | 1 | Rejected record in the previous cycle |

## Verification
A record and a flush can arrive in the same cycle, and so can a direct write and a record. The bench first loads explicit flags that differ from what an add record would produce. It then drives an add record together with a flush and expects the add's flags, because a flush that won would keep the old flags. It also pairs a write with a record and a write with a flush and expects the written value each time. A write paired with an undefined tag must keep the written value and still raise the error.

// File: rtl/lazy_ccr_pkg.sv
package lazy_ccr_pkg;
  localparam int unsigned TAG_W = 4;
  localparam int unsigned CCR_W = 5;

  typedef enum logic [TAG_W-1:0] {
    TAG_FLAGS = 4'd0,
    TAG_ADD_B = 4'd1, TAG_ADD_W = 4'd2, TAG_ADD_L = 4'd3,
    TAG_SUB_B = 4'd4, TAG_SUB_W = 4'd5, TAG_SUB_L = 4'd6,
    TAG_CMP_B = 4'd7, TAG_CMP_W = 4'd8, TAG_CMP_L = 4'd9,
    TAG_LOGIC = 4'd10
  } cc_tag_e;

  typedef enum logic [2:0] {
    OPC_FLAGS, OPC_ADD, OPC_SUB, OPC_CMP, OPC_LOGIC, OPC_BAD
  } op_class_e;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2} op_size_e;

  // bit 4 .. bit 0
  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/lazy_ccr_decode.sv
module lazy_ccr_decode
  import lazy_ccr_pkg::*;
(
  input  logic [TAG_W-1:0] tag_i,
  output op_class_e        cls_o,
  output op_size_e         size_o
);
  logic [TAG_W-1:0] off;

  always_comb begin
    off   = '0;
    cls_o = OPC_BAD;
    if (tag_i == TAG_FLAGS) begin
      cls_o = OPC_FLAGS;
    end else if (tag_i <= TAG_ADD_L) begin
      cls_o = OPC_ADD;
      off   = tag_i - TAG_ADD_B;
    end else if (tag_i <= TAG_SUB_L) begin
      cls_o = OPC_SUB;
      off   = tag_i - TAG_SUB_B;
    end else if (tag_i <= TAG_CMP_L) begin
      cls_o = OPC_CMP;
      off   = tag_i - TAG_CMP_B;
    end else if (tag_i == TAG_LOGIC) begin
      cls_o = OPC_LOGIC;
    end
  end

  // size is the distance from the class's byte tag
  always_comb begin
    if (off == TAG_W'(0))      size_o = SZ_BYTE;
    else if (off == TAG_W'(1)) size_o = SZ_WORD;
    else                       size_o = SZ_LONG;
  end
endmodule

// File: rtl/lazy_ccr_sext.sv
module lazy_ccr_sext
  import lazy_ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] val_i,
  input  op_size_e          size_i,
  output logic [DATA_W-1:0] val_o
);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;

  generate
    if (DATA_W > WORD_W) begin : g_wide
      always_comb begin
        unique case (size_i)
          SZ_BYTE: val_o = {{(DATA_W-BYTE_W){val_i[BYTE_W-1]}}, val_i[BYTE_W-1:0]};
          SZ_WORD: val_o = {{(DATA_W-WORD_W){val_i[WORD_W-1]}}, val_i[WORD_W-1:0]};
          default: val_o = val_i;
        endcase
      end
    end else begin : g_narrow
      always_comb begin
        if (size_i == SZ_BYTE) val_o = {{(DATA_W-BYTE_W){val_i[BYTE_W-1]}}, val_i[BYTE_W-1:0]};
        else                   val_o = val_i;
      end
    end
  endgenerate
endmodule

// File: rtl/lazy_ccr_eval.sv
module lazy_ccr_eval
  import lazy_ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] n_i,
  input  logic [DATA_W-1:0] z_i,
  input  logic [DATA_W-1:0] v_i,
  input  logic [DATA_W-1:0] c_i,
  output logic [DATA_W-1:0] x_o,
  output logic [DATA_W-1:0] n_o,
  output logic [DATA_W-1:0] z_o,
  output logic [DATA_W-1:0] v_o,
  output logic [DATA_W-1:0] c_o,
  output ccr_t              ccr_o
);
  localparam int unsigned MSB = DATA_W - 1;

  op_class_e         cls;
  op_size_e          size;
  logic [DATA_W-1:0] arith;
  logic [DATA_W-1:0] ext;
  logic              lt;

  lazy_ccr_decode i_decode (.tag_i(tag_i), .cls_o(cls), .size_o(size));

  // one adder: add recovers src1 = res - src2, sub recovers src1 = res + src2,
  // compare rebuilds res = src1 - src2
  assign arith = (cls == OPC_SUB) ? (n_i + v_i) : (n_i - v_i);
  assign lt    = n_i < v_i;

  lazy_ccr_sext #(.DATA_W(DATA_W)) i_sext (.val_i(arith), .size_i(size), .val_o(ext));

  always_comb begin
    x_o = x_i;
    n_o = n_i;
    z_o = z_i;
    v_o = v_i;
    c_o = c_i;
    unique case (cls)
      OPC_ADD: begin
        z_o = n_i;
        c_o = x_i;
        v_o = (n_i ^ ext) & ~(ext ^ v_i);
      end
      OPC_SUB: begin
        z_o = n_i;
        c_o = x_i;
        v_o = (n_i ^ ext) & (ext ^ v_i);
      end
      OPC_CMP: begin
        n_o = ext;
        z_o = ext;
        c_o = {{(DATA_W-1){1'b0}}, lt};
        v_o = (ext ^ n_i) & (n_i ^ v_i);
      end
      OPC_LOGIC: begin
        z_o = n_i;
        v_o = '0;
        c_o = '0;
      end
      default: ;
    endcase
  end

  assign ccr_o = '{x: x_o[0], n: n_o[MSB], z: ~|z_o, v: v_o[MSB], c: c_o[0]};
endmodule

// File: rtl/lazy_ccr_state.sv
module lazy_ccr_state
  import lazy_ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_take_i,
  input  logic              rec_bad_i,
  input  logic [TAG_W-1:0]  rec_tag_i,
  input  logic [DATA_W-1:0] rec_x_i,
  input  logic [DATA_W-1:0] rec_n_i,
  input  logic [DATA_W-1:0] rec_z_i,
  input  logic [DATA_W-1:0] rec_v_i,
  input  logic [DATA_W-1:0] rec_c_i,
  input  logic              ccr_we_i,
  input  ccr_t              ccr_wdata_i,
  input  logic              flush_i,
  input  logic [DATA_W-1:0] fl_x_i,
  input  logic [DATA_W-1:0] fl_n_i,
  input  logic [DATA_W-1:0] fl_z_i,
  input  logic [DATA_W-1:0] fl_v_i,
  input  logic [DATA_W-1:0] fl_c_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] x_o,
  output logic [DATA_W-1:0] n_o,
  output logic [DATA_W-1:0] z_o,
  output logic [DATA_W-1:0] v_o,
  output logic [DATA_W-1:0] c_o,
  output logic              err_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o <= TAG_FLAGS;
      x_o   <= '0;
      n_o   <= '0;
      z_o   <= ONE;  // nonzero: Z clear after reset
      v_o   <= '0;
      c_o   <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= rec_bad_i;
      if (ccr_we_i) begin
        tag_o <= TAG_FLAGS;
        x_o   <= {{(DATA_W-1){1'b0}}, ccr_wdata_i.x};
        n_o   <= {DATA_W{ccr_wdata_i.n}};
        z_o   <= {{(DATA_W-1){1'b0}}, ~ccr_wdata_i.z};
        v_o   <= {DATA_W{ccr_wdata_i.v}};
        c_o   <= {{(DATA_W-1){1'b0}}, ccr_wdata_i.c};
      end else if (rec_take_i) begin
        tag_o <= rec_tag_i;
        x_o   <= rec_x_i;
        n_o   <= rec_n_i;
        z_o   <= rec_z_i;
        v_o   <= rec_v_i;
        c_o   <= rec_c_i;
      end else if (flush_i) begin
        tag_o <= TAG_FLAGS;
        x_o   <= fl_x_i;
        n_o   <= fl_n_i;
        z_o   <= fl_z_i;
        v_o   <= fl_v_i;
        c_o   <= fl_c_i;
      end
    end
  end
endmodule

// File: rtl/lazy_ccr.sv
module lazy_ccr
  import lazy_ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_valid_i,
  input  logic [3:0]        rec_tag_i,
  input  logic [DATA_W-1:0] rec_x_i,
  input  logic [DATA_W-1:0] rec_n_i,
  input  logic [DATA_W-1:0] rec_z_i,
  input  logic [DATA_W-1:0] rec_v_i,
  input  logic [DATA_W-1:0] rec_c_i,
  input  logic              ccr_we_i,
  input  logic [4:0]        ccr_wdata_i,
  input  logic              flush_i,
  output logic [4:0]        ccr_o,
  output logic              tag_err_o
);
  logic              tag_ok;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] x_q, n_q, z_q, v_q, c_q;
  logic [DATA_W-1:0] x_f, n_f, z_f, v_f, c_f;
  ccr_t              ccr;

  assign tag_ok = rec_tag_i <= TAG_LOGIC;

  lazy_ccr_state #(.DATA_W(DATA_W)) i_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rec_take_i  (rec_valid_i & tag_ok),
    .rec_bad_i   (rec_valid_i & ~tag_ok),
    .rec_tag_i   (rec_tag_i),
    .rec_x_i     (rec_x_i),
    .rec_n_i     (rec_n_i),
    .rec_z_i     (rec_z_i),
    .rec_v_i     (rec_v_i),
    .rec_c_i     (rec_c_i),
    .ccr_we_i    (ccr_we_i),
    .ccr_wdata_i (ccr_t'(ccr_wdata_i)),
    .flush_i     (flush_i),
    .fl_x_i      (x_f),
    .fl_n_i      (n_f),
    .fl_z_i      (z_f),
    .fl_v_i      (v_f),
    .fl_c_i      (c_f),
    .tag_o       (tag_q),
    .x_o         (x_q),
    .n_o         (n_q),
    .z_o         (z_q),
    .v_o         (v_q),
    .c_o         (c_q),
    .err_o       (tag_err_o)
  );

  lazy_ccr_eval #(.DATA_W(DATA_W)) i_eval (
    .tag_i (tag_q),
    .x_i   (x_q),
    .n_i   (n_q),
    .z_i   (z_q),
    .v_i   (v_q),
    .c_i   (c_q),
    .x_o   (x_f),
    .n_o   (n_f),
    .z_o   (z_f),
    .v_o   (v_f),
    .c_o   (c_f),
    .ccr_o (ccr)
  );

  assign ccr_o = ccr;
endmodule

// File: rtl/lazy_ccr_chk.sv
module lazy_ccr_chk
  import lazy_ccr_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rec_valid_i,
  input logic [3:0] rec_tag_i,
  input logic       ccr_we_i,
  input logic [4:0] ccr_wdata_i,
  input logic       flush_i,
  input logic [4:0] ccr_o,
  input logic       tag_err_o
);
  logic bad_rec;
  assign bad_rec = rec_valid_i && (rec_tag_i > TAG_LOGIC);

  assert_write_back_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccr_we_i |=> ccr_o == $past(ccr_wdata_i));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ccr_we_i && !rec_valid_i && !flush_i |=> $stable(ccr_o));

  assert_logic_vc_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && rec_tag_i == TAG_LOGIC && !ccr_we_i |=> ccr_o[1:0] == 2'b00);

  assert_flush_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !ccr_we_i && !rec_valid_i |=> ccr_o == $past(ccr_o));

  assert_bad_tag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_rec && !ccr_we_i |=> tag_err_o && ccr_o == $past(ccr_o));

  assert_no_spurious_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_rec |=> !tag_err_o);
endmodule

bind lazy_ccr lazy_ccr_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rec_valid_i (rec_valid_i),
  .rec_tag_i   (rec_tag_i),
  .ccr_we_i    (ccr_we_i),
  .ccr_wdata_i (ccr_wdata_i),
  .flush_i     (flush_i),
  .ccr_o       (ccr_o),
  .tag_err_o   (tag_err_o)
);

// File: tb/test_lazy_ccr.sv
module test_lazy_ccr;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rec_valid = 1'b0;
  logic [3:0]    rec_tag = '0;
  logic [DW-1:0] rec_x = '0, rec_n = '0, rec_z = '0, rec_v = '0, rec_c = '0;
  logic          ccr_we = 1'b0;
  logic [4:0]    ccr_wdata = '0;
  logic          flush = 1'b0;
  logic [4:0]    ccr_o;
  logic          tag_err_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lazy_ccr #(.DATA_W(DW)) i_lazy_ccr (
    .clk_i(clk), .rst_ni(rst_ni), .rec_valid_i(rec_valid), .rec_tag_i(rec_tag),
    .rec_x_i(rec_x), .rec_n_i(rec_n), .rec_z_i(rec_z), .rec_v_i(rec_v), .rec_c_i(rec_c),
    .ccr_we_i(ccr_we), .ccr_wdata_i(ccr_wdata), .flush_i(flush),
    .ccr_o(ccr_o), .tag_err_o(tag_err_o)
  );

  logic [31:0] corner [3][8] = '{
    '{32'h00, 32'h01, 32'h7F, 32'h80, 32'h81, 32'hFE, 32'hFF, 32'h55},
    '{32'h0000, 32'h0001, 32'h7FFF, 32'h8000, 32'h8001, 32'hFFFE, 32'hFFFF, 32'h1234},
    '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'h80000001, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h12345678}
  };

  function automatic logic [31:0] sx(logic [31:0] v, int w);
    logic [31:0] m;
    if (w == 32) return v;
    m = (32'h1 << w) - 32'h1;
    if (v[w-1]) return v | ~m;
    return v & m;
  endfunction

  task automatic chk(string req, logic [4:0] got, logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: ccr got %05b expected %05b", req, got, exp);
    end
  endtask

  task automatic chk_err(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: tag_err got %b expected %b", req, got, exp);
    end
  endtask

  task automatic clear_in();
    rec_valid = 1'b0;
    ccr_we = 1'b0;
    flush = 1'b0;
  endtask

  // inputs are set at posedge+1; outputs are sampled one edge later at posedge+1
  task automatic step();
    @(posedge clk);
    #1;
    clear_in();
  endtask

  task automatic set_rec(logic [3:0] t, logic [31:0] x, n, z, v, c);
    rec_valid = 1'b1; rec_tag = t;
    rec_x = x; rec_n = n; rec_z = z; rec_v = v; rec_c = c;
  endtask

  task automatic do_write(logic [4:0] w);
    ccr_we = 1'b1; ccr_wdata = w;
    step();
  endtask

  task automatic do_flush();
    flush = 1'b1;
    step();
  endtask

  // kind 0 add, 1 sub, 2 cmp; sz 0 byte, 1 word, 2 long
  task automatic arith(int kind, int sz, logic [31:0] a, logic [31:0] b, logic xin, bit with_flush);
    int w;
    longint unsigned mask, ma, mb, r;
    longint sa, sb, ss, hi, lo;
    logic cy, ov, nb;
    logic [4:0] exp;
    string req;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (64'd1 << w) - 64'd1;
    ma = {32'h0, a} & mask;
    mb = {32'h0, b} & mask;
    sa = (ma >= (64'd1 << (w-1))) ? longint'(ma) - longint'(64'd1 << w) : longint'(ma);
    sb = (mb >= (64'd1 << (w-1))) ? longint'(mb) - longint'(64'd1 << w) : longint'(mb);
    hi = longint'((64'd1 << (w-1)) - 64'd1);
    lo = -longint'(64'd1 << (w-1));
    if (kind == 0) begin
      r  = (ma + mb) & mask;
      cy = ((ma + mb) >> w) != 0;
      ss = sa + sb;
    end else begin
      r  = (ma - mb) & mask;
      cy = ma < mb;
      ss = sa - sb;
    end
    ov = (ss > hi) || (ss < lo);
    nb = r[w-1];
    req = (kind == 0) ? "R3 add" : (kind == 1) ? "R4 sub" : "R5 cmp";
    if (sz < 2) req = {req, " R7 size"};
    if (kind < 2) begin
      exp = {cy, nb, r == 0, ov, cy};
      // Z and C slots carry junk that must be ignored
      set_rec(4'(1 + 3*kind + sz), {31'h0, cy}, sx(r[31:0], w), 32'hDEADBEEF, sx(mb[31:0], w), {31'h0, ~cy});
    end else begin
      exp = {xin, nb, r == 0, ov, cy};
      set_rec(4'(1 + 3*kind + sz), {31'h0, xin}, sx(ma[31:0], w), 32'h0, sx(mb[31:0], w), 32'h0);
    end
    step();
    chk($sformatf("%s a=%h b=%h", req, a, b), ccr_o, exp);
    if (with_flush) begin
      do_flush();
      chk($sformatf("R8 flush after %s a=%h b=%h", req, a, b), ccr_o, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in reset", ccr_o, 5'b00000);
    chk_err("R1 in reset", tag_err_o, 1'b0);
    rst_ni = 1'b1;
    step();
    chk("R1 after reset", ccr_o, 5'b00000);
    chk_err("R1 after reset", tag_err_o, 1'b0);

    // R2: every write value reads back; idle cycle holds
    for (int i = 0; i < 32; i++) begin
      do_write(5'(i));
      chk($sformatf("R2 write %0d", i), ccr_o, 5'(i));
    end
    step();
    chk("R2 idle hold", ccr_o, 5'h1F);

    // R2: explicit-flag record decoding of the slots
    set_rec(4'd0, 32'h1, 32'h80000000, 32'h0, 32'h7FFFFFFF, 32'h2);
    step();
    chk("R2 explicit slots a", ccr_o, 5'b11100);
    set_rec(4'd0, 32'h2, 32'h7FFFFFFF, 32'h100, 32'h80000000, 32'h3);
    step();
    chk("R2 explicit slots b", ccr_o, 5'b00011);
    do_flush();
    chk("R8 flush explicit", ccr_o, 5'b00011);

    // R6: logic record
    set_rec(4'd10, 32'h1, 32'h0, 32'h5, 32'hFFFFFFFF, 32'h1);
    step();
    chk("R6 logic zero", ccr_o, 5'b10100);
    set_rec(4'd10, 32'h0, 32'h80000001, 32'h0, 32'h80000000, 32'hFFFFFFFF);
    step();
    chk("R6 logic negative", ccr_o, 5'b01000);
    do_flush();
    chk("R8 flush logic", ccr_o, 5'b01000);

    // R3 R4 R5 R7: corner sweeps at each size
    for (int k = 0; k < 3; k++)
      for (int s = 0; s < 3; s++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            arith(k, s, corner[s][i], corner[s][j], 1'((i + j) & 1), 1'b1);

    // near-exhaustive byte sweep
    for (int k = 0; k < 3; k++)
      for (int a = 0; a < 256; a += 5)
        for (int b = 0; b < 256; b += 7)
          arith(k, 0, 32'(a), 32'(b), 1'(a & 1), ((a + b) % 3) == 0);

    // strided word sweep
    for (int k = 0; k < 3; k++)
      for (int a = 0; a < 65536; a += 4099)
        for (int b = 0; b < 65536; b += 3989)
          arith(k, 1, 32'(a), 32'(b), 1'(b & 1), 1'b0);

    // R9: undefined tags
    do_write(5'b10101);
    for (int t = 11; t < 16; t++) begin
      set_rec(4'(t), 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
      step();
      chk($sformatf("R9 tag %0d ccr", t), ccr_o, 5'b10101);
      chk_err($sformatf("R9 tag %0d err", t), tag_err_o, 1'b1);
      step();
      chk_err($sformatf("R9 tag %0d err clears", t), tag_err_o, 1'b0);
    end

    // R10: same-cycle priority (add byte 0x7F+0x01 gives 01010)
    ccr_we = 1'b1; ccr_wdata = 5'h11;
    set_rec(4'd1, 32'h0, 32'hFFFFFF80, 32'h0, 32'h1, 32'h0);
    step();
    chk("R10 write over record", ccr_o, 5'h11);
    set_rec(4'd1, 32'h0, 32'hFFFFFF80, 32'h0, 32'h1, 32'h0);
    flush = 1'b1;
    step();
    chk("R10 record over flush", ccr_o, 5'b01010);
    ccr_we = 1'b1; ccr_wdata = 5'h04;
    flush = 1'b1;
    step();
    chk("R10 write over flush", ccr_o, 5'h04);
    ccr_we = 1'b1; ccr_wdata = 5'h1F;
    set_rec(4'd13, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
    step();
    chk("R10 write with bad tag", ccr_o, 5'h1F);
    chk_err("R9 R10 bad tag with write", tag_err_o, 1'b1);
    step();
    chk("R2 hold after priority", ccr_o, 5'h1F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule